// File: doc/BRIEF.md
# 128-bit SIMD Lane Permute Unit

This block takes two 128-bit source operands and rearranges their 32-bit words, 16-bit halfwords or bytes into one 128-bit destination value. An opcode picks one of nine fixed shuffle patterns. The patterns are: pack of the even words, interleave of the low elements at three element sizes, interleave of the high words, halfword broadcast inside each 64-bit half, two doubleword copies, and a rotate of the three lowest words. The unit does no arithmetic. Every result bit is a copy of one source bit, or zero.

The unit sits beside a register file. With each request it receives the source register indices and the destination register index. A source index of zero means the architectural zero register, so that operand is read as all zeros whatever its data bus carries. A destination index of zero suppresses the write. The result, the destination index and the write-enable are registered and appear one clock after the request.

Top module: `lane_perm_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_we`, `out_rd` and `out_data` are cleared to zero at that edge.
- R2: A request with `in_valid` high is presented on `out_we`, `out_rd` and `out_data` after exactly one rising edge, and `out_rd` equals the `rd_idx` of that request.
- R3: Opcode 0 (pack even words) yields result words, from word 0 up: T word 0, T word 2, S word 0, S word 2. Here S is the gated rs operand and T is the gated rt operand.
- R4: Opcode 3 (interleave low words) yields result words, from word 0 up: T word 0, S word 0, T word 1, S word 1.
- R5: Opcode 4 (interleave high words) yields result words, from word 0 up: T word 2, S word 2, T word 3, S word 3.
- R6: Opcode 1 works on bytes and opcode 2 on halfwords. Each interleaves the elements of the low 64 bits of the operands: result element 2i is T element i and result element 2i+1 is S element i.
- R7: Opcode 5 (broadcast) fills all four halfwords of the result's low 64 bits with T halfword 0, and all four halfwords of its high 64 bits with T halfword 4.
- R8: Opcode 6 gives result bits 63:0 = T bits 63:0 and result bits 127:64 = S bits 63:0. Opcode 7 gives result bits 63:0 = S bits 127:64 and result bits 127:64 = T bits 127:64.
- R9: Opcode 8 (rotate three words) yields result words, from word 0 up: T word 1, T word 2, T word 0, T word 3. Word 3 stays in place.
- R10: A valid request with `rd_idx` equal to 0 leaves `out_we` low in the next cycle.
- R11: A source index of 0 makes that operand read as all zeros. A broadcast or rotate with `rt_idx` 0 therefore gives an all-zero result with `out_we` high.
- R12: An opcode outside 0 to 8 leaves `out_we` low in the next cycle. A cycle with `in_valid` low also leaves `out_we` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Shuffle opcode, encoded 0 to 8 |
| rs_idx | input | 5 | Register index of the first source |
| rt_idx | input | 5 | Register index of the second source |
| rd_idx | input | 5 | Register index of the destination |
| rs_data | input | 128 | First source value |
| rt_data | input | 128 | Second source value |
| out_we | output | 1 | Registered write-enable |
| out_rd | output | 5 | Registered destination index |
| out_data | output | 128 | Registered shuffled result |

## Verification
Every byte of the two stimulus operands is distinct, and the two operands use disjoint byte values. A pattern that pulls the wrong element, takes it from the wrong operand, or swaps the operand order therefore shows up as a wrong byte in a known position. The bench drives a zero index on each source in turn. A unit that ignored the index would leak the data bus into a broadcast or rotate result where all zeros are expected. A zero destination and an undefined opcode are both applied. A unit that failed to suppress either would raise a write-enable that should stay low. Reset is also asserted right after a valid request, to catch a reset that does not win over the pending result.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;

    localparam int unsigned VEC_W  = 128;
    localparam int unsigned HALF_W = VEC_W / 2;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HW_W   = 16;
    localparam int unsigned OP_W   = 4;
    localparam int unsigned N_WORD = VEC_W / WORD_W;
    localparam int unsigned HW_PER_HALF = HALF_W / HW_W;

    typedef enum logic [OP_W-1:0] {
        OP_PACK_EVEN_W = 4'd0,
        OP_ILV_LO_B    = 4'd1,
        OP_ILV_LO_H    = 4'd2,
        OP_ILV_LO_W    = 4'd3,
        OP_ILV_HI_W    = 4'd4,
        OP_BCAST_H     = 4'd5,
        OP_COPY_LO_D   = 4'd6,
        OP_COPY_HI_D   = 4'd7,
        OP_ROT3_W      = 4'd8
    } perm_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd8;

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t word_of(input vec_t v, input int unsigned idx);
        return v[idx*WORD_W +: WORD_W];
    endfunction

    function automatic logic op_known(input logic [OP_W-1:0] code);
        return code <= OP_LAST;
    endfunction

endpackage

// File: rtl/lane_perm_src_gate.sv
module lane_perm_src_gate #(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned DATA_W = 128
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] gated
);
    // index 0 names the hard-wired zero register
    assign gated = (idx == '0) ? '0 : raw;
endmodule

// File: rtl/lane_perm_interleave.sv
module lane_perm_interleave #(
    parameter int unsigned ELEM_W = 8,
    parameter int unsigned SRC_W  = 64
) (
    input  logic [SRC_W-1:0]   even_src,
    input  logic [SRC_W-1:0]   odd_src,
    output logic [2*SRC_W-1:0] mixed
);
    localparam int unsigned N_ELEM = SRC_W / ELEM_W;

    for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
        assign mixed[(2*i)*ELEM_W   +: ELEM_W] = even_src[i*ELEM_W +: ELEM_W];
        assign mixed[(2*i+1)*ELEM_W +: ELEM_W] = odd_src[i*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/lane_perm_shuffle.sv
module lane_perm_shuffle
    import lane_perm_pkg::*;
(
    input  perm_op_e op,
    input  vec_t     src_s,
    input  vec_t     src_t,
    output vec_t     shuffled,
    output logic     known
);
    localparam int unsigned N_ILV = 3;

    vec_t ilv_lo [N_ILV];
    vec_t ilv_hi_w;
    vec_t bcast;

    // low-half interleave at byte, halfword and word size
    for (genvar g = 0; g < N_ILV; g++) begin : g_ilv
        lane_perm_interleave #(
            .ELEM_W (8 << g),
            .SRC_W  (HALF_W)
        ) ilv_i (
            .even_src (src_t[HALF_W-1:0]),
            .odd_src  (src_s[HALF_W-1:0]),
            .mixed    (ilv_lo[g])
        );
    end

    lane_perm_interleave #(
        .ELEM_W (WORD_W),
        .SRC_W  (HALF_W)
    ) ilv_hi_i (
        .even_src (src_t[VEC_W-1:HALF_W]),
        .odd_src  (src_s[VEC_W-1:HALF_W]),
        .mixed    (ilv_hi_w)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        for (genvar k = 0; k < HW_PER_HALF; k++) begin : g_lane
            assign bcast[h*HALF_W + k*HW_W +: HW_W] = src_t[h*HALF_W +: HW_W];
        end
    end

    always_comb begin
        known    = 1'b1;
        shuffled = '0;
        unique case (op)
            OP_PACK_EVEN_W: shuffled = {word_of(src_s, 2), word_of(src_s, 0),
                                        word_of(src_t, 2), word_of(src_t, 0)};
            OP_ILV_LO_B:    shuffled = ilv_lo[0];
            OP_ILV_LO_H:    shuffled = ilv_lo[1];
            OP_ILV_LO_W:    shuffled = ilv_lo[2];
            OP_ILV_HI_W:    shuffled = ilv_hi_w;
            OP_BCAST_H:     shuffled = bcast;
            OP_COPY_LO_D:   shuffled = {src_s[HALF_W-1:0], src_t[HALF_W-1:0]};
            OP_COPY_HI_D:   shuffled = {src_t[VEC_W-1:HALF_W], src_s[VEC_W-1:HALF_W]};
            OP_ROT3_W:      shuffled = {word_of(src_t, 3), word_of(src_t, 0),
                                        word_of(src_t, 2), word_of(src_t, 1)};
            default:        known = 1'b0;
        endcase
    end
endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit
    import lane_perm_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [IDX_W-1:0]  rs_idx,
    input  logic [IDX_W-1:0]  rt_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [VEC_W-1:0]  rs_data,
    input  logic [VEC_W-1:0]  rt_data,
    output logic              out_we,
    output logic [IDX_W-1:0]  out_rd,
    output logic [VEC_W-1:0]  out_data
);
    vec_t opnd_s, opnd_t, shuf;
    logic op_ok;

    lane_perm_src_gate #(.IDX_W(IDX_W), .DATA_W(VEC_W)) gate_s_i (
        .idx (rs_idx), .raw (rs_data), .gated (opnd_s)
    );

    lane_perm_src_gate #(.IDX_W(IDX_W), .DATA_W(VEC_W)) gate_t_i (
        .idx (rt_idx), .raw (rt_data), .gated (opnd_t)
    );

    lane_perm_shuffle shuf_i (
        .op       (perm_op_e'(in_op)),
        .src_s    (opnd_s),
        .src_t    (opnd_t),
        .shuffled (shuf),
        .known    (op_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_we   <= 1'b0;
            out_rd   <= '0;
            out_data <= '0;
        end else begin
            out_we <= in_valid && op_ok && (rd_idx != '0);
            if (in_valid) begin
                out_rd   <= rd_idx;
                out_data <= op_ok ? shuf : '0;
            end
        end
    end

    AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_we);  // R12

    AST_ZERO_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rd_idx == '0) |=> !out_we);  // R10

    AST_BAD_OP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > OP_LAST) |=> !out_we);  // R12

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_rd == $past(rd_idx));  // R2

    AST_ZERO_SRC_BCAST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_BCAST_H && rt_idx == '0) |=> out_data == '0);  // R11

    AST_ROT_TOP_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_ROT3_W && rt_idx != '0)
        |=> out_data[VEC_W-1 -: WORD_W] == $past(rt_data[VEC_W-1 -: WORD_W]));  // R9

    AST_COPY_LO_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_COPY_LO_D && rt_idx != '0)
        |=> out_data[HALF_W-1:0] == $past(rt_data[HALF_W-1:0]));  // R8

endmodule

// File: tb/lane_perm_unit_tb_top.sv
module lane_perm_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 5000;
    localparam int NV         = 15;

    localparam logic [127:0] RS_VAL = 128'h1f1e1d1c_1b1a1918_17161514_13121110;
    localparam logic [127:0] RT_VAL = 128'h0f0e0d0c_0b0a0908_07060504_03020100;

    localparam logic [3:0] V_OP [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
                                         4'd8, 4'd3, 4'd8, 4'd5, 4'd0, 4'hF, 4'd6};
    localparam logic [4:0] V_RS [NV] = '{5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 5'd1,
                                         5'd1, 5'd0, 5'd1, 5'd1, 5'd1, 5'd1, 5'd0};
    localparam logic [4:0] V_RT [NV] = '{5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 5'd2, 5'd2,
                                         5'd2, 5'd2, 5'd0, 5'd0, 5'd2, 5'd2, 5'd2};
    localparam logic [4:0] V_RD [NV] = '{5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10,
                                         5'd11, 5'd12, 5'd13, 5'd14, 5'd0, 5'd15, 5'd31};
    localparam logic V_WE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                   1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [127:0] V_EXP [NV] = '{
        128'h1b1a1918_13121110_0b0a0908_03020100,   // pack even words
        128'h17071606_15051404_13031202_11011000,   // interleave low bytes
        128'h1716_0706_1514_0504_1312_0302_1110_0100, // interleave low halfwords
        128'h17161514_07060504_13121110_03020100,   // interleave low words
        128'h1f1e1d1c_0f0e0d0c_1b1a1918_0b0a0908,   // interleave high words
        128'h0908090809080908_0100010001000100,     // broadcast
        128'h1716151413121110_0706050403020100,     // copy low doublewords
        128'h0f0e0d0c0b0a0908_1f1e1d1c1b1a1918,     // copy high doublewords
        128'h0f0e0d0c_03020100_0b0a0908_07060504,   // rotate three words
        128'h00000000_07060504_00000000_03020100,   // rs zero
        128'h0,                                     // rotate of zero reg
        128'h0,                                     // broadcast of zero reg
        128'h0,
        128'h0,
        128'h0000000000000000_0706050403020100      // copy low, rs zero
    };
    localparam string V_TAG [NV] = '{"R3", "R6", "R6", "R4", "R5", "R7", "R8", "R8",
                                     "R9", "R11", "R11", "R11", "R10", "R12", "R11"};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [4:0]   rs_idx = '0, rt_idx = '0, rd_idx = '0;
    logic [127:0] rs_data = RS_VAL, rt_data = RT_VAL;
    logic         out_we;
    logic [4:0]   out_rd;
    logic [127:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    lane_perm_unit dut_i (
        .clk, .rst, .in_valid, .in_op, .rs_idx, .rt_idx, .rd_idx,
        .rs_data, .rt_data, .out_we, .out_rd, .out_data
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD_LIMIT) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] op, input logic [4:0] s,
                         input logic [4:0] t, input logic [4:0] d);
        in_valid = v; in_op = op; rs_idx = s; rt_idx = t; rd_idx = d;
    endtask

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        check("R1", "we in reset", {127'b0, out_we}, 128'h0);
        check("R1", "rd in reset", {123'b0, out_rd}, 128'h0);
        check("R1", "data in reset", out_data, 128'h0);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, V_OP[i], V_RS[i], V_RT[i], V_RD[i]);
            @(negedge clk);
            check(V_TAG[i], "we", {127'b0, out_we}, {127'b0, V_WE[i]});
            check("R2", "rd", {123'b0, out_rd}, {123'b0, V_RD[i]});
            if (V_WE[i]) check(V_TAG[i], "data", out_data, V_EXP[i]);
        end

        // R12: valid low
        drive(1'b0, 4'd0, 5'd1, 5'd2, 5'd3);
        @(negedge clk);
        check("R12", "we with valid low", {127'b0, out_we}, 128'h0);

        // R2: no output change before the edge
        drive(1'b1, 4'd8, 5'd1, 5'd2, 5'd20);
        #1;
        check("R2", "we before edge", {127'b0, out_we}, 128'h0);
        @(negedge clk);
        check("R2", "we after one edge", {127'b0, out_we}, 128'h1);
        check("R2", "rd after one edge", {123'b0, out_rd}, {123'b0, 5'd20});

        // R1: reset right after a valid request
        drive(1'b1, 4'd6, 5'd1, 5'd2, 5'd21);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "we after reset", {127'b0, out_we}, 128'h0);
        check("R1", "data after reset", out_data, 128'h0);
        rst = 1'b0;
        drive(1'b0, 4'd0, 5'd0, 5'd0, 5'd0);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule